// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block carries one fixed-size page between a byte-wide flash card data port and system memory. The page always passes through an on-chip page buffer, so every transfer has two phases: an internal phase between the card port and the buffer, and a memory phase between the buffer and memory. Software picks the direction, loads a memory base address and the interrupt enables, and starts the first phase. The block then runs both phases, arms the second phase when the first one ends, and reports the outcome with a one-cycle completion or failure pulse and with interrupt status bits.

A stage counter tracks progress. It is set to 1 at launch and goes up by one at the end of each phase. When it reaches 2 the other phase is armed. When it would reach 3 the transfer is finished. A bus error input aborts the transfer at any point. At finish or abort the settings, the interrupt enables and the address register return to a safe state, so a stray beat cannot reach an address that software did not choose. The memory side is a single-beat request/acknowledge port. The card side is a valid/ready byte handshake in each direction.

Top module: `pgdma_seq`

## Requirements
- R1: After reset the settings register (0) reads 0, the address register (1) reads SAFE_ADDR (default 0x1000), the enables (2), status (3) and stage (5) read 0, and irq, done_pulse, fail_pulse, mem_req, card_in_ready and card_out_valid are low.
- R2: A write to register 0 launches a transfer when the stage is 0, both capability inputs are 1, and exactly one phase bit is set (bit 1 internal, bit 2 memory). Bit 0 gives the direction (1 = card to memory). The stage reads 1 in the next cycle.
- R3: A launch attempt is ignored when the capability inputs are not both 1, when no phase bit or both phase bits are set, or when the stage is not 0. Writes to the address register are also ignored while the stage is not 0.
- R4: In the internal phase with direction 1, the block accepts card bytes into buffer positions 0 to PAGE_BYTES-1 in order, on card_in_valid and card_in_ready. With direction 0 it offers buffer bytes in the same order on card_out_data with card_out_valid and moves on at card_out_ready.
- R5: In the memory phase, mem_req stays high and mem_addr is the base plus 4 times the beat number. Each beat carries buffer bytes idx to idx+3 with byte idx in bits 7:0. Direction 1 writes memory (mem_we high, mem_wdata). Direction 0 reads it, storing mem_rdata at mem_ack.
- R6: When the last byte or beat of a phase completes, that phase's status bit is set (bit 0 internal, bit 1 memory) and the stage advances. From stage 1 the other phase runs, starting in the next cycle.
- R7: When the second phase completes, done_pulse is high for one cycle. The stage, the settings and the enables return to 0, and the address register is reloaded with SAFE_ADDR.
- R8: bus_err sets status bit 2 and applies the R7 cleanup at any stage. fail_pulse is high for one cycle if the stage was not 0. An error in the same cycle as the final phase completion wins, so done_pulse stays low.
- R9: Writing 1 to a status bit (register 3) clears it, and a 0 leaves it unchanged. A hardware set in the same cycle as the clear wins.
- R10: irq is high exactly when some status bit and its enable bit (register 2, same positions) are both 1.
- R11: Register 4 reports the two capability inputs in bits 1:0, and bit 2 is 1 only when both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_bits | input | 2 | Two DMA-present strap bits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| card_in_valid | input | 1 | Card byte offered to the block |
| card_in_data | input | 8 | Card byte from the card |
| card_in_ready | output | 1 | Block accepts a card byte |
| card_out_valid | output | 1 | Block offers a byte to the card |
| card_out_data | output | 8 | Byte to the card |
| card_out_ready | input | 1 | Card takes the offered byte |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a memory write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | 8*BEAT_BYTES | Beat write data |
| mem_rdata | input | 8*BEAT_BYTES | Beat read data, valid with mem_ack |
| mem_ack | input | 1 | Beat completes |
| bus_err | input | 1 | Memory-side error, aborts the transfer |
| irq | output | 1 | Interrupt request |
| done_pulse | output | 1 | One-cycle successful completion |
| fail_pulse | output | 1 | One-cycle aborted transfer |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a bus error and the final handshake of the second phase. With every handshake held ready, the bench waits until its model sits at the last byte of the second phase and raises bus_err in that cycle. It then expects fail_pulse without done_pulse, and all three status bits set. The second pair is a software clear of a status bit and the hardware setting of that same bit. The bench writes the clear in the cycle of the last internal byte and expects the bit to read back as 1.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
    // register indices
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_ADDR  = 3'd1;
    localparam logic [2:0] RA_IEN   = 3'd2;
    localparam logic [2:0] RA_ISTAT = 3'd3;
    localparam logic [2:0] RA_CAP   = 3'd4;
    localparam logic [2:0] RA_STAGE = 3'd5;

    // settings bits
    localparam int B_DIR  = 0;
    localparam int B_SELI = 1;
    localparam int B_SELM = 2;

    // cause bits (status and enable share positions)
    localparam int C_INT = 0;
    localparam int C_MEM = 1;
    localparam int C_ERR = 2;

    typedef struct packed {
        logic       dir;
        logic       sel_int;
        logic       sel_mem;
        logic [1:0] stage;
        logic [2:0] ien;
        logic [2:0] ist;
        logic       done;
        logic       fail;
    } seq_t;
endpackage

// File: rtl/pgdma_pagebuf.sv
module pgdma_pagebuf #(
    parameter int DEPTH = 512,
    parameter int LANES = 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic [IW-1:0]      idx,
    input  logic               byte_we,
    input  logic [7:0]         byte_wdata,
    input  logic               word_we,
    input  logic [8*LANES-1:0] word_wdata,
    output logic [7:0]         rd_byte,
    output logic [8*LANES-1:0] rd_word
);
    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (byte_we) cell_q[idx] <= byte_wdata;
        if (word_we) begin
            for (int k = 0; k < LANES; k++) begin
                cell_q[idx + IW'(k)] <= word_wdata[8*k +: 8];
            end
        end
    end

    assign rd_byte = cell_q[idx];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign rd_word[8*g +: 8] = cell_q[idx + IW'(g)];
        end
    endgenerate
endmodule

// File: rtl/pgdma_mover.sv
module pgdma_mover #(
    parameter int PAGE  = 512,
    parameter int LANES = 4,
    localparam int IW = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_act,
    input  logic          mem_act,
    input  logic          dir,
    input  logic          card_in_valid,
    input  logic          card_out_ready,
    input  logic          mem_ack,
    output logic [IW-1:0] idx,
    output logic          int_fire,
    output logic          mem_fire,
    output logic          int_last,
    output logic          mem_last,
    output logic          card_in_ready,
    output logic          card_out_valid,
    output logic          mem_req,
    output logic          mem_we
);
    localparam logic [IW-1:0] LAST_BYTE = IW'(PAGE - 1);
    localparam logic [IW-1:0] LAST_BEAT = IW'(PAGE - LANES);
    localparam logic [IW-1:0] STEP      = IW'(LANES);

    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
        card_in_ready  = int_act && dir;
        card_out_valid = int_act && !dir;
        mem_req        = mem_act;
        mem_we         = mem_act && dir;
        int_fire       = int_act && (dir ? card_in_valid : card_out_ready);
        mem_fire       = mem_act && mem_ack;
        int_last       = int_fire && (idx_q == LAST_BYTE);
        mem_last       = mem_fire && (idx_q == LAST_BEAT);

        idx_d = idx_q;
        if (int_last || mem_last || (!int_act && !mem_act)) idx_d = '0;
        else if (int_fire) idx_d = idx_q + 1'b1;
        else if (mem_fire) idx_d = idx_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act |-> (idx_q % IW'(LANES)) == '0);   // R5
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int_fire && !int_last) |=> idx_q == $past(idx_q) + 1'b1);   // R4
endmodule

// File: rtl/pgdma_seq.sv
module pgdma_seq
    import pgdma_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int BEAT_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] SAFE_ADDR = 'h1000,
    localparam int IW = $clog2(PAGE_BYTES),
    localparam int MW = 8 * BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cap_bits,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              card_in_valid,
    input  logic [7:0]        card_in_data,
    output logic              card_in_ready,
    output logic              card_out_valid,
    output logic [7:0]        card_out_data,
    input  logic              card_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MW-1:0]     mem_wdata,
    input  logic [MW-1:0]     mem_rdata,
    input  logic              mem_ack,
    input  logic              bus_err,
    output logic              irq,
    output logic              done_pulse,
    output logic              fail_pulse
);
    seq_t              s_d, s_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [IW-1:0]     idx;
    logic              int_fire, mem_fire, int_last, mem_last;
    logic              int_act, mem_act, idle, usable, finish;
    logic [1:0]        stage_nx;

    assign idle    = (s_q.stage == 2'd0);
    assign usable  = &cap_bits;
    assign int_act = !idle && s_q.sel_int;
    assign mem_act = !idle && s_q.sel_mem;

    pgdma_mover #(.PAGE(PAGE_BYTES), .LANES(BEAT_BYTES)) u_mover (
        .clk(clk), .rst_n(rst_n), .int_act(int_act), .mem_act(mem_act), .dir(s_q.dir),
        .card_in_valid(card_in_valid), .card_out_ready(card_out_ready), .mem_ack(mem_ack),
        .idx(idx), .int_fire(int_fire), .mem_fire(mem_fire),
        .int_last(int_last), .mem_last(mem_last),
        .card_in_ready(card_in_ready), .card_out_valid(card_out_valid),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    pgdma_pagebuf #(.DEPTH(PAGE_BYTES), .LANES(BEAT_BYTES)) u_buf (
        .clk(clk), .idx(idx),
        .byte_we(int_fire && s_q.dir), .byte_wdata(card_in_data),
        .word_we(mem_fire && !s_q.dir), .word_wdata(mem_rdata),
        .rd_byte(card_out_data), .rd_word(mem_wdata)
    );

    assign mem_addr = addr_q + ADDR_W'(idx);
    assign irq      = |(s_q.ist & s_q.ien);
    assign done_pulse = s_q.done;
    assign fail_pulse = s_q.fail;

    always_comb begin
        s_d      = s_q;
        addr_d   = addr_q;
        s_d.done = 1'b0;
        s_d.fail = 1'b0;
        finish   = 1'b0;
        stage_nx = s_q.stage + 2'd1;

        if (reg_we && reg_addr == RA_IEN) s_d.ien = reg_wdata[2:0];
        if (reg_we && reg_addr == RA_ADDR && idle) addr_d = reg_wdata[ADDR_W-1:0];
        if (reg_we && reg_addr == RA_CTRL && idle && usable &&
            (reg_wdata[B_SELI] ^ reg_wdata[B_SELM])) begin
            s_d.stage   = 2'd1;
            s_d.dir     = reg_wdata[B_DIR];
            s_d.sel_int = reg_wdata[B_SELI];
            s_d.sel_mem = reg_wdata[B_SELM];
        end

        s_d.ist = (s_q.ist & ~((reg_we && reg_addr == RA_ISTAT) ? reg_wdata[2:0] : 3'b000))
                | {bus_err, mem_last, int_last};

        if (int_last || mem_last) begin
            if (stage_nx == 2'd3) begin
                finish = 1'b1;
            end else begin
                s_d.stage   = stage_nx;
                s_d.sel_int = s_q.sel_mem;
                s_d.sel_mem = s_q.sel_int;
            end
        end

        if (finish || bus_err) begin
            s_d.stage   = 2'd0;
            s_d.dir     = 1'b0;
            s_d.sel_int = 1'b0;
            s_d.sel_mem = 1'b0;
            s_d.ien     = 3'b000;
            addr_d      = SAFE_ADDR;
            s_d.done    = finish && !bus_err;
            s_d.fail    = bus_err && !idle;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            addr_q <= SAFE_ADDR;
        end else begin
            s_q    <= s_d;
            addr_q <= addr_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata[2:0] = {s_q.sel_mem, s_q.sel_int, s_q.dir};
            RA_ADDR:  reg_rdata      = 32'(addr_q);
            RA_IEN:   reg_rdata[2:0] = s_q.ien;
            RA_ISTAT: reg_rdata[2:0] = s_q.ist;
            RA_CAP:   reg_rdata[2:0] = {usable, cap_bits};
            RA_STAGE: reg_rdata[1:0] = s_q.stage;
            default:  reg_rdata      = '0;
        endcase
    end

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.sel_int && s_q.sel_mem));   // R2
    AST_ACTIVE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stage != 2'd0) |-> (s_q.sel_int ^ s_q.sel_mem));   // R6
    AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.ist[C_INT] || s_q.ist[C_MEM]));   // R6
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.stage == 2'd0 && s_q.ien == 3'b000 && addr_q == SAFE_ADDR));   // R7
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.done && s_q.fail));   // R8
    AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fail |-> s_q.ist[C_ERR]);   // R8
    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fail |=> !s_q.fail);   // R8
endmodule

// File: tb/tb_pgdma_seq.sv
module tb_pgdma_seq;
    localparam int PAGE = 512;
    localparam logic [31:0] SAFE = 32'h1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cap_bits = 2'b11;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic card_in_valid = 1'b0, card_in_ready, card_out_valid, card_out_ready = 1'b0;
    logic [7:0] card_in_data = 8'd0, card_out_data;
    logic mem_req, mem_we, mem_ack = 1'b0, bus_err = 1'b0, irq, done_pulse, fail_pulse;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'd0;

    always #2.5 clk = ~clk;   // 200 MHz

    pgdma_seq dut (
        .clk(clk), .rst_n(rst_n), .cap_bits(cap_bits),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_in_valid(card_in_valid), .card_in_data(card_in_data), .card_in_ready(card_in_ready),
        .card_out_valid(card_out_valid), .card_out_data(card_out_data), .card_out_ready(card_out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .bus_err(bus_err),
        .irq(irq), .done_pulse(done_pulse), .fail_pulse(fail_pulse)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit fast = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_stage = 0, m_idx = 0;
    bit m_dir = 0, m_si = 0, m_sm = 0, m_done = 0, m_fail = 0;
    logic [31:0] m_addr = SAFE;
    logic [2:0] m_en = 0, m_stat = 0;
    logic [7:0] m_pg [PAGE];

    always @(posedge clk) begin
        bit ia, ma, fi, fm, li, lm, fin;
        int nst, nidx;
        if (!rst_n) begin
            m_stage = 0; m_idx = 0; m_dir = 0; m_si = 0; m_sm = 0;
            m_done = 0; m_fail = 0; m_addr = SAFE; m_en = 0; m_stat = 0;
        end else begin
            ia = (m_stage != 0) && m_si;
            ma = (m_stage != 0) && m_sm;
            fi = ia && (m_dir ? card_in_valid : card_out_ready);
            fm = ma && mem_ack;
            li = fi && (m_idx == PAGE - 1);
            lm = fm && (m_idx == PAGE - 4);
            if (fi && m_dir) m_pg[m_idx] = card_in_data;
            if (fm && !m_dir) for (int k = 0; k < 4; k++) m_pg[m_idx + k] = mem_rdata[8*k +: 8];
            if (li || lm || (!ia && !ma)) nidx = 0;
            else if (fi) nidx = m_idx + 1;
            else if (fm) nidx = m_idx + 4;
            else nidx = m_idx;
            if (reg_we && reg_addr == 3) m_stat = m_stat & ~reg_wdata[2:0];
            m_stat = m_stat | {bus_err, lm, li};
            m_done = 0; m_fail = 0; fin = 0;
            nst = m_stage;
            if (reg_we && reg_addr == 2) m_en = reg_wdata[2:0];
            if (reg_we && reg_addr == 1 && m_stage == 0) m_addr = reg_wdata;
            if (reg_we && reg_addr == 0 && m_stage == 0 && cap_bits == 2'b11 &&
                (reg_wdata[1] != reg_wdata[2])) begin
                nst = 1; m_dir = reg_wdata[0]; m_si = reg_wdata[1]; m_sm = reg_wdata[2];
            end
            if (li || lm) begin
                if (m_stage == 1) begin nst = 2; m_si = !m_si; m_sm = !m_sm; end
                else fin = 1;
            end
            if (fin || bus_err) begin
                m_done = fin && !bus_err;
                m_fail = bus_err && (m_stage != 0);
                nst = 0; m_dir = 0; m_si = 0; m_sm = 0; m_en = 0; m_addr = SAFE;
            end
            m_stage = nst;
            m_idx = nidx;
        end
    end

    // per-cycle comparison of every output against the model
    always @(negedge clk) begin
        bit ca, cm;
        logic [31:0] w;
        if (rst_n) begin
            ca = (m_stage != 0) && m_si;
            cm = (m_stage != 0) && m_sm;
            check("R4 card_in_ready", card_in_ready, ca && m_dir);
            check("R4 card_out_valid", card_out_valid, ca && !m_dir);
            if (ca && !m_dir) check("R4 card_out_data", card_out_data, m_pg[m_idx]);
            check("R5 mem_req", mem_req, cm);
            if (cm) begin
                check("R5 mem_we", mem_we, m_dir);
                check("R5 mem_addr", mem_addr, m_addr + m_idx);
                if (m_dir) begin
                    for (int k = 0; k < 4; k++) w[8*k +: 8] = m_pg[m_idx + k];
                    check("R5 mem_wdata", mem_wdata, w);
                end
            end
            check("R10 irq", irq, |(m_stat & m_en));
            check("R7 done_pulse", done_pulse, m_done);
            check("R8 fail_pulse", fail_pulse, m_fail);
        end
    end

    // card and memory responders
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        card_in_data = lfsr[15:8];
        mem_rdata = {lfsr, ~lfsr ^ 16'h5A3C};
        if (fast) begin
            card_in_valid = 1; card_out_ready = 1; mem_ack = 1;
        end else begin
            card_in_valid = lfsr[0] | lfsr[3];
            card_out_ready = lfsr[1] | lfsr[6];
            mem_ack = lfsr[2] & lfsr[5];
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic wait_end(input string tag);
        int k = 0;
        do begin @(negedge clk); k++; end while (done_pulse !== 1'b1 && fail_pulse !== 1'b1 && k < 5000);
        check(tag, done_pulse, 1'b1);
    endtask

    initial begin
        int k;
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(3'd0, 32'd0, "R1 settings after reset");
        rd(3'd1, SAFE, "R1 address after reset");
        rd(3'd2, 32'd0, "R1 enables after reset");
        rd(3'd3, 32'd0, "R1 status after reset");
        rd(3'd5, 32'd0, "R1 stage after reset");
        check("R1 irq after reset", irq, 1'b0);
        // R11 / R3 capability gating
        cap_bits = 2'b01;
        rd(3'd4, 32'd1, "R11 capability one bit");
        wr(3'd0, 32'h3);
        rd(3'd5, 32'd0, "R3 launch without capability");
        cap_bits = 2'b11;
        rd(3'd4, 32'd7, "R11 capability both bits");
        wr(3'd0, 32'h7);
        rd(3'd5, 32'd0, "R3 launch with both phase bits");
        wr(3'd0, 32'h1);
        rd(3'd5, 32'd0, "R3 launch with no phase bit");

        // read transfer, irregular handshakes
        wr(3'd2, 32'h3);
        wr(3'd1, 32'h4000);
        wr(3'd0, 32'h3);
        rd(3'd5, 32'd1, "R2 stage after launch");
        rd(3'd0, 32'h3, "R2 settings after launch");
        wr(3'd1, 32'h9000);
        rd(3'd1, 32'h4000, "R3 address write while busy");
        k = 0;
        do begin @(negedge clk); k++; end while (m_stage != 2 && k < 5000);
        check("R6 internal phase then memory", m_stage, 2);
        check("R10 irq on internal done", irq, 1'b1);
        wr(3'd0, 32'h3);
        rd(3'd0, 32'h5, "R3 settings write while busy");
        wr(3'd3, 32'h1);
        rd(3'd3, 32'd0, "R9 status cleared by write one");
        check("R10 irq low after clear", irq, 1'b0);
        wait_end("R7 read transfer completes");
        rd(3'd5, 32'd0, "R7 stage idle");
        rd(3'd2, 32'd0, "R7 enables cleared");
        rd(3'd1, SAFE, "R7 address reloaded");
        rd(3'd0, 32'd0, "R7 settings cleared");
        rd(3'd3, 32'h2, "R6 memory status set");
        wr(3'd3, 32'h7);

        // write transfer: memory phase first
        wr(3'd2, 32'h7);
        wr(3'd1, 32'h8000);
        wr(3'd0, 32'h4);
        wait_end("R7 write transfer completes");
        rd(3'd3, 32'h3, "R6 both phase status bits");
        wr(3'd3, 32'h7);

        // abort mid internal phase
        wr(3'd0, 32'h3);
        repeat (100) @(negedge clk);
        #1 bus_err = 1;
        @(negedge clk);
        check("R8 fail pulse on abort", fail_pulse, 1'b1);
        #1 bus_err = 0;
        rd(3'd3, 32'h4, "R8 error status");
        rd(3'd5, 32'd0, "R8 stage idle after abort");
        wr(3'd3, 32'h7);

        // error on the final handshake of the second phase
        fast = 1;
        wr(3'd0, 32'h4);
        k = 0;
        do begin @(negedge clk); k++; end while (!(m_stage == 2 && m_si && m_idx == PAGE - 1) && k < 5000);
        #1 bus_err = 1;
        @(negedge clk);
        check("R8 error wins fail", fail_pulse, 1'b1);
        check("R8 error wins no done", done_pulse, 1'b0);
        #1 bus_err = 0;
        rd(3'd3, 32'h7, "R8 all status bits");
        wr(3'd3, 32'h7);

        // clear and set of the same status bit in one cycle
        wr(3'd0, 32'h3);
        k = 0;
        do begin @(negedge clk); k++; end while (!(m_stage == 1 && m_si && m_idx == PAGE - 1) && k < 5000);
        #1 reg_we = 1; reg_addr = 3'd3; reg_wdata = 32'h1;
        @(negedge clk); #1 reg_we = 0;
        rd(3'd3, 32'h1, "R9 set wins over clear");
        wait_end("R7 fast read completes");
        rd(3'd3, 32'h3, "R6 status after fast read");
        fast = 0;

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule